// File: doc/BRIEF.md
# PID-tagged translation lookaside buffer

This block is a small, fully associative store of recent virtual-to-physical page translations. It sits in front of a page table walker. Each stored translation carries the process ID that owns it, so a context switch only changes the ID presented with each lookup. Nothing has to be invalidated. A lookup supplies a virtual page key, a process ID, an operation type and the page offset. The offset never enters the buffer. It is joined below the cached frame number to form the physical address.

A lookup is answered in the same cycle. On a hit the buffer returns the frame, the permission bits and the physical address. A hit whose permissions forbid the operation raises a fault instead. A miss raises a walk request. The walker may start its walk alongside the lookup. When the walker finishes, it returns the translation on the fill port, and the buffer installs it on the next clock edge.

Software can clear every entry at once. It can also clear only the entries that belong to one process ID.

Top module: `xlat_cache`

## Requirements
- R1: With `lk_valid` high, a lookup hits when a stored valid entry has the same page key and the same process ID. In that same cycle `hit_frame` and `hit_perm` carry that entry's fields, and `paddr` equals the frame placed above `lk_offset`.
- R2: An entry with the same page key but a different process ID does not hit. A fill whose key and process ID equal those of a valid entry overwrites that entry, so at most one entry ever matches a lookup.
- R3: `walk_req` is high in the same cycle exactly when `lk_valid` is high and no entry hits. It stays low while `lk_valid` is low.
- R4: A fill writes the matching entry described in R2 if one exists. Otherwise it writes the lowest-numbered invalid entry. Otherwise it writes the entry at a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping after the last entry, on every accepted fill.
- R5: Permission bit 0 allows read, bit 1 allows write and bit 2 allows execute. `lk_op` is coded 0 = read, 1 = write, 2 = execute, and code 3 is never permitted. A hit that lacks the needed bit sets `fault` and leaves `walk_req` low.
- R6: A cycle with `flush_all` high leaves every entry invalid from the next cycle on.
- R7: A cycle with `flush_pid_en` high invalidates only the entries whose process ID equals `flush_pid`. All other entries keep hitting.
- R8: A fill presented in the same cycle as either flush is ignored. The round-robin pointer does not move in that cycle.
- R9: After reset every entry is invalid, so every valid lookup misses and requests a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_pid | input | PID_W (8) | Process ID of the lookup |
| lk_vpn | input | VPN_W (20) | Virtual page key of the lookup |
| lk_offset | input | OFF_W (12) | Page offset, passed through to the physical address |
| lk_op | input | 2 | Operation: 0 read, 1 write, 2 execute, 3 reserved |
| hit | output | 1 | Lookup matched a valid entry |
| fault | output | 1 | Hit, but the operation is not permitted |
| walk_req | output | 1 | Miss; the walker must translate |
| hit_frame | output | FRAME_W (18) | Frame number of the hit entry |
| hit_perm | output | 3 | Permission bits of the hit entry |
| paddr | output | FRAME_W+OFF_W (30) | Frame joined with the offset |
| fill_valid | input | 1 | Walker returns a translation |
| fill_pid | input | PID_W (8) | Process ID of the fill |
| fill_vpn | input | VPN_W (20) | Page key of the fill |
| fill_frame | input | FRAME_W (18) | Frame number of the fill |
| fill_perm | input | 3 | Permission bits of the fill |
| flush_all | input | 1 | Invalidate every entry |
| flush_pid_en | input | 1 | Invalidate the entries of one process ID |
| flush_pid | input | PID_W (8) | Process ID to invalidate |

## Verification
The in-RTL properties assume a few things about the inputs:
- Reset is held for at least one clock edge.
- Command inputs carry known values on every clock edge.
- A fill is not relied on during a flush cycle.

The uniqueness property on the match vector therefore holds only because duplicate fills are folded onto their existing entry. The stimulus changes inputs only on falling edges and returns every command line to zero between operations. Fills and flushes coincide only in the dedicated test that targets that collision.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int PERM_W = 3;
   localparam int P_RD   = 0;
   localparam int P_WR   = 1;
   localparam int P_EX   = 2;

   typedef enum logic [1:0] {
      OP_LOAD  = 2'd0,
      OP_STORE = 2'd1,
      OP_FETCH = 2'd2,
      OP_RSVD  = 2'd3
   } xop_e;

   // Decide whether a permission set allows an operation
   function automatic logic op_allowed(input logic [PERM_W-1:0] perm, input xop_e op);
      case (op)
         OP_LOAD:  return perm[P_RD];
         OP_STORE: return perm[P_WR];
         OP_FETCH: return perm[P_EX];
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/xlat_slot.sv
module xlat_slot #(
   parameter int PID_W   = 8,
   parameter int VPN_W   = 20,
   parameter int FRAME_W = 18,
   parameter int PERM_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [PID_W-1:0]   wr_pid,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [FRAME_W-1:0] wr_frame,
   input  logic [PERM_W-1:0]  wr_perm,
   input  logic               clr_all,
   input  logic               clr_pid_en,
   input  logic [PID_W-1:0]   clr_pid,
   input  logic [PID_W-1:0]   lk_pid,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic               valid,
   output logic               lk_match,
   output logic               wr_match,
   output logic [FRAME_W-1:0] frame_q,
   output logic [PERM_W-1:0]  perm_q
);

   logic             v_q;
   logic [PID_W-1:0] pid_q;
   logic [VPN_W-1:0] vpn_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                              v_q <= 1'b0;
      else if (clr_all)                        v_q <= 1'b0;
      else if (clr_pid_en && pid_q == clr_pid) v_q <= 1'b0;
      else if (wr_en)                          v_q <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         pid_q   <= wr_pid;
         vpn_q   <= wr_vpn;
         frame_q <= wr_frame;
         perm_q  <= wr_perm;
      end
   end

   assign valid    = v_q;
   assign lk_match = v_q && (pid_q == lk_pid) && (vpn_q == lk_vpn);
   assign wr_match = v_q && (pid_q == wr_pid) && (vpn_q == wr_vpn);

   AST_PID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pid_en && v_q && pid_q == clr_pid) |=> !v_q);                  // R7
   AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_all && !clr_pid_en) |=> v_q);                         // R1

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int ENTRIES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_go,
   input  logic [ENTRIES-1:0] valid,
   input  logic [ENTRIES-1:0] dup,
   output logic [ENTRIES-1:0] wr_sel
);

   localparam int  IDX_W = $clog2(ENTRIES);
   localparam bit  POW2  = (ENTRIES == (1 << IDX_W));
   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr_q, ptr_nxt, pick, free_idx, dup_idx;
   logic             free_any, dup_any;

   always_comb begin
      free_any = 1'b0;
      dup_any  = 1'b0;
      free_idx = '0;
      dup_idx  = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid[i]) begin
            free_any = 1'b1;
            free_idx = IDX_W'(i);
         end
         if (dup[i]) begin
            dup_any = 1'b1;
            dup_idx = IDX_W'(i);
         end
      end
      if (dup_any)       pick = dup_idx;
      else if (free_any) pick = free_idx;
      else               pick = ptr_q;
      wr_sel = '0;
      if (fill_go) wr_sel[pick] = 1'b1;
   end

   generate
      if (POW2) begin : g_wrap_free
         assign ptr_nxt = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nxt = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr_q <= '0;
      else if (fill_go) ptr_q <= ptr_nxt;
   end

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fill_go |=> $stable(ptr_q));                                        // R8
   AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_go && !(|dup) && !(&valid)) |-> ((wr_sel & valid) == '0));     // R4

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int PID_W   = 8,
   parameter int VPN_W   = 20,
   parameter int FRAME_W = 18,
   parameter int OFF_W   = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lk_valid,
   input  logic [PID_W-1:0]         lk_pid,
   input  logic [VPN_W-1:0]         lk_vpn,
   input  logic [OFF_W-1:0]         lk_offset,
   input  logic [1:0]               lk_op,
   output logic                     hit,
   output logic                     fault,
   output logic                     walk_req,
   output logic [FRAME_W-1:0]       hit_frame,
   output logic [PERM_W-1:0]        hit_perm,
   output logic [FRAME_W+OFF_W-1:0] paddr,
   input  logic                     fill_valid,
   input  logic [PID_W-1:0]         fill_pid,
   input  logic [VPN_W-1:0]         fill_vpn,
   input  logic [FRAME_W-1:0]       fill_frame,
   input  logic [PERM_W-1:0]        fill_perm,
   input  logic                     flush_all,
   input  logic                     flush_pid_en,
   input  logic [PID_W-1:0]         flush_pid
);

   localparam int PA_W = FRAME_W + OFF_W;

   initial begin : elab_checks
      if (ENTRIES < 2)  $error("xlat_cache: ENTRIES must be at least 2");
      if (PID_W < 1)    $error("xlat_cache: PID_W must be positive");
      if (VPN_W < 1)    $error("xlat_cache: VPN_W must be positive");
      if (FRAME_W < 1)  $error("xlat_cache: FRAME_W must be positive");
   end

   logic [ENTRIES-1:0] slot_valid, slot_match, slot_dup, slot_wr;
   logic [FRAME_W-1:0] slot_frame [ENTRIES];
   logic [PERM_W-1:0]  slot_perm  [ENTRIES];
   logic               fill_go, any_match, allowed;

   assign fill_go = fill_valid && !flush_all && !flush_pid_en;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
         xlat_slot #(
            .PID_W(PID_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W), .PERM_W(PERM_W)
         ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (slot_wr[g]),
            .wr_pid    (fill_pid),
            .wr_vpn    (fill_vpn),
            .wr_frame  (fill_frame),
            .wr_perm   (fill_perm),
            .clr_all   (flush_all),
            .clr_pid_en(flush_pid_en),
            .clr_pid   (flush_pid),
            .lk_pid    (lk_pid),
            .lk_vpn    (lk_vpn),
            .valid     (slot_valid[g]),
            .lk_match  (slot_match[g]),
            .wr_match  (slot_dup[g]),
            .frame_q   (slot_frame[g]),
            .perm_q    (slot_perm[g])
         );
      end
   endgenerate

   xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk    (clk),
      .rst_n  (rst_n),
      .fill_go(fill_go),
      .valid  (slot_valid),
      .dup    (slot_dup),
      .wr_sel (slot_wr)
   );

   // One-hot match vector, so an OR of gated fields is the selected entry
   always_comb begin
      hit_frame = '0;
      hit_perm  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (slot_match[i]) begin
            hit_frame = hit_frame | slot_frame[i];
            hit_perm  = hit_perm  | slot_perm[i];
         end
      end
   end

   assign any_match = |slot_match;
   assign allowed   = op_allowed(hit_perm, xop_e'(lk_op));
   assign hit       = lk_valid && any_match;
   assign fault     = hit && !allowed;
   assign walk_req  = lk_valid && !any_match;
   assign paddr     = PA_W'({hit_frame, lk_offset});

   AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_match));                                               // R2
   AST_FAULT_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !walk_req);                                                // R5
   AST_IDLE_NO_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> !walk_req);                                            // R3
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> (slot_valid == '0));                                   // R6

endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
   import xlat_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int N_ENT = 8;
   localparam int PID_W = 8;
   localparam int VPN_W = 20;
   localparam int FRM_W = 18;
   localparam int OFF_W = 12;

   localparam logic [1:0] K_LOOK = 2'd0, K_FILL = 2'd1, K_FALL = 2'd2, K_FPID = 2'd3;

   typedef struct packed {
      logic [1:0]       kind;
      logic [PID_W-1:0] pid;
      logic [VPN_W-1:0] vpn;
      logic [FRM_W-1:0] frame;
      logic [2:0]       perm;
      logic [1:0]       op;
   } vec_t;

   localparam int N_VEC = 19;
   localparam vec_t VT [N_VEC] = '{
      '{K_FILL, 8'h01, 20'h00010, 18'h00100, 3'b011, 2'd0},
      '{K_FILL, 8'h01, 20'h00011, 18'h00101, 3'b101, 2'd0},
      '{K_FILL, 8'h02, 20'h00010, 18'h00200, 3'b111, 2'd0},
      '{K_LOOK, 8'h01, 20'h00010, 18'h0,     3'b000, 2'd0},
      '{K_LOOK, 8'h01, 20'h00010, 18'h0,     3'b000, 2'd1},
      '{K_LOOK, 8'h01, 20'h00010, 18'h0,     3'b000, 2'd2},
      '{K_LOOK, 8'h02, 20'h00010, 18'h0,     3'b000, 2'd2},
      '{K_LOOK, 8'h03, 20'h00010, 18'h0,     3'b000, 2'd0},
      '{K_LOOK, 8'h01, 20'h00011, 18'h0,     3'b000, 2'd1},
      '{K_LOOK, 8'h01, 20'h00011, 18'h0,     3'b000, 2'd3},
      '{K_LOOK, 8'h01, 20'h00011, 18'h0,     3'b000, 2'd2},
      '{K_FILL, 8'h01, 20'h00010, 18'h001AB, 3'b111, 2'd0},
      '{K_LOOK, 8'h01, 20'h00010, 18'h0,     3'b000, 2'd2},
      '{K_FPID, 8'h01, 20'h0,     18'h0,     3'b000, 2'd0},
      '{K_LOOK, 8'h01, 20'h00011, 18'h0,     3'b000, 2'd0},
      '{K_LOOK, 8'h01, 20'h00010, 18'h0,     3'b000, 2'd0},
      '{K_LOOK, 8'h02, 20'h00010, 18'h0,     3'b000, 2'd0},
      '{K_FALL, 8'h00, 20'h0,     18'h0,     3'b000, 2'd0},
      '{K_LOOK, 8'h02, 20'h00010, 18'h0,     3'b000, 2'd0}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_valid = 1'b0;
   logic [PID_W-1:0] lk_pid = '0;
   logic [VPN_W-1:0] lk_vpn = '0;
   logic [OFF_W-1:0] lk_offset = '0;
   logic [1:0] lk_op = '0;
   logic hit, fault, walk_req;
   logic [FRM_W-1:0] hit_frame;
   logic [2:0] hit_perm;
   logic [FRM_W+OFF_W-1:0] paddr;
   logic fill_valid = 1'b0;
   logic [PID_W-1:0] fill_pid = '0;
   logic [VPN_W-1:0] fill_vpn = '0;
   logic [FRM_W-1:0] fill_frame = '0;
   logic [2:0] fill_perm = '0;
   logic flush_all = 1'b0, flush_pid_en = 1'b0;
   logic [PID_W-1:0] flush_pid = '0;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // Reference model state
   bit               m_v   [N_ENT];
   logic [PID_W-1:0] m_pid [N_ENT];
   logic [VPN_W-1:0] m_vpn [N_ENT];
   logic [FRM_W-1:0] m_frm [N_ENT];
   logic [2:0]       m_prm [N_ENT];
   int               m_ptr;

   always #(CLK_PERIOD / 2) clk = ~clk;

   xlat_cache #(.ENTRIES(N_ENT), .PID_W(PID_W), .VPN_W(VPN_W), .FRAME_W(FRM_W), .OFF_W(OFF_W)) u0 (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pid(lk_pid), .lk_vpn(lk_vpn), .lk_offset(lk_offset), .lk_op(lk_op),
      .hit(hit), .fault(fault), .walk_req(walk_req), .hit_frame(hit_frame), .hit_perm(hit_perm),
      .paddr(paddr),
      .fill_valid(fill_valid), .fill_pid(fill_pid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
      .fill_perm(fill_perm),
      .flush_all(flush_all), .flush_pid_en(flush_pid_en), .flush_pid(flush_pid)
   );

   task automatic idle();
      lk_valid = 1'b0; fill_valid = 1'b0; flush_all = 1'b0; flush_pid_en = 1'b0;
   endtask

   task automatic m_fill(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                         input logic [FRM_W-1:0] f, input logic [2:0] pm);
      int idx = -1;
      for (int i = 0; i < N_ENT; i++)
         if (idx < 0 && m_v[i] && m_pid[i] == p && m_vpn[i] == v) idx = i;
      for (int i = 0; i < N_ENT; i++)
         if (idx < 0 && !m_v[i]) idx = i;
      if (idx < 0) idx = m_ptr;
      m_v[idx] = 1'b1; m_pid[idx] = p; m_vpn[idx] = v; m_frm[idx] = f; m_prm[idx] = pm;
      m_ptr = (m_ptr + 1) % N_ENT;
   endtask

   task automatic do_fill(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                          input logic [FRM_W-1:0] f, input logic [2:0] pm);
      @(negedge clk); idle();
      fill_valid = 1'b1; fill_pid = p; fill_vpn = v; fill_frame = f; fill_perm = pm;
      @(posedge clk);
      m_fill(p, v, f, pm);
      #1 idle();
   endtask

   task automatic do_flush(input bit all, input logic [PID_W-1:0] p, input bit with_fill,
                           input logic [VPN_W-1:0] v);
      @(negedge clk); idle();
      flush_all = all; flush_pid_en = !all; flush_pid = p;
      if (with_fill) begin
         fill_valid = 1'b1; fill_pid = 8'h07; fill_vpn = v; fill_frame = 18'h3FFFF; fill_perm = 3'b111;
      end
      @(posedge clk);
      for (int i = 0; i < N_ENT; i++)
         if (all || m_pid[i] == p) m_v[i] = 1'b0;
      #1 idle();
   endtask

   task automatic chk_look(input logic [PID_W-1:0] p, input logic [VPN_W-1:0] v,
                           input logic [1:0] op, input bit lv, input string tag);
      bit eh = 1'b0, ok, ef, ew, bad;
      logic [FRM_W-1:0] efr = '0;
      logic [2:0] epm = '0;
      logic [FRM_W+OFF_W-1:0] epa;
      @(negedge clk); idle();
      lk_valid = lv; lk_pid = p; lk_vpn = v; lk_op = op;
      lk_offset = v[OFF_W-1:0] ^ 12'hC3A;
      #1;
      for (int i = 0; i < N_ENT; i++)
         if (m_v[i] && m_pid[i] == p && m_vpn[i] == v) begin eh = 1'b1; efr = m_frm[i]; epm = m_prm[i]; end
      eh = eh && lv;
      case (op)
         2'd0: ok = epm[0];
         2'd1: ok = epm[1];
         2'd2: ok = epm[2];
         default: ok = 1'b0;
      endcase
      ef  = eh && !ok;
      ew  = lv && !eh;
      epa = {efr, lk_offset};
      bad = ({hit, fault, walk_req} != {eh, ef, ew});
      if (eh && (paddr != epa || hit_perm != epm)) bad = 1'b1;
      n_chk++;
      if (bad) begin
         n_bad++;
         $display("FAIL %s: hit/fault/walk=%b%b%b paddr=%h perm=%b expected %b%b%b paddr=%h perm=%b",
                  tag, hit, fault, walk_req, paddr, hit_perm, eh, ef, ew, epa, epm);
      end
      @(posedge clk);
      #1 idle();
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run still active, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      for (int i = 0; i < N_ENT; i++) begin
         m_v[i] = 1'b0; m_pid[i] = '0; m_vpn[i] = '0; m_frm[i] = '0; m_prm[i] = '0;
      end
      m_ptr = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9: empty after reset; R3: no walk without a lookup
      chk_look(8'h01, 20'h00010, 2'd0, 1'b1, "R9 reset miss");
      chk_look(8'h01, 20'h00010, 2'd0, 1'b0, "R3 idle no walk");

      // Vector table: R1 hits, R2 pid isolation and overwrite, R5 permissions, R7, R6
      for (int k = 0; k < N_VEC; k++) begin
         case (VT[k].kind)
            K_FILL: do_fill(VT[k].pid, VT[k].vpn, VT[k].frame, VT[k].perm);
            K_FALL: do_flush(1'b1, '0, 1'b0, '0);
            K_FPID: do_flush(1'b0, VT[k].pid, 1'b0, '0);
            default: chk_look(VT[k].pid, VT[k].vpn, VT[k].op, 1'b1,
                              $sformatf("R1 R2 R5 R6 R7 vector %0d", k));
         endcase
      end

      // R4: fill ten entries, one owned by pid 9, pointer eviction
      do_flush(1'b1, '0, 1'b0, '0);
      for (int i = 0; i < 10; i++)
         do_fill((i == 3) ? 8'h09 : 8'h07, 20'h00100 + 20'(i), 18'h01000 + 18'(i), 3'b001);
      for (int i = 0; i < 10; i++)
         chk_look((i == 3) ? 8'h09 : 8'h07, 20'h00100 + 20'(i), 2'd0, 1'b1, "R4 eviction");
      // R4: a freed entry is used before the pointer
      do_flush(1'b0, 8'h09, 1'b0, '0);
      do_fill(8'h07, 20'h00200, 18'h02000, 3'b010);
      chk_look(8'h07, 20'h00200, 2'd1, 1'b1, "R4 free slot fill");
      chk_look(8'h07, 20'h00102, 2'd0, 1'b1, "R4 pointer entry kept");

      // R8: fill during a flush is dropped and the pointer stays put
      do_flush(1'b0, 8'h55, 1'b1, 20'h00300);
      chk_look(8'h07, 20'h00300, 2'd0, 1'b1, "R8 fill dropped in pid flush");
      do_fill(8'h07, 20'h00301, 18'h03001, 3'b001);
      chk_look(8'h07, 20'h00102, 2'd0, 1'b1, "R8 pointer unchanged");
      chk_look(8'h07, 20'h00301, 2'd0, 1'b1, "R8 later fill lands");
      do_flush(1'b1, '0, 1'b1, 20'h00302);
      chk_look(8'h07, 20'h00302, 2'd0, 1'b1, "R8 fill dropped in full flush");
      chk_look(8'h07, 20'h00301, 2'd0, 1'b1, "R6 full flush");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule